// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block judges a single physical memory access against a small table of protection regions and returns a verdict: allowed or denied, and on denial the exception cause a core would raise. Each access belongs to one of five classes: data read, data write, read-modify-write (atomic), instruction fetch, and cache-block maintenance. Cache-block maintenance is treated as a class of its own. It needs both read and write permission, and a denial is reported as a store/AMO access fault. For cache operations the block also returns the subtype that the operation maps to. Clean and flush share one subtype, invalidate has its own, and a zero subtype is also encoded.

Regions are configured through plain, quasi-static pins. Each region has read/write/execute permission bits, a lock bit, a match mode (off, top-of-range, or naturally aligned power-of-two) and an address word. The table is searched in ascending index order, and the lowest-numbered region that matches decides the verdict. In machine mode, permissions are enforced only for a locked region. When no region matches, only machine mode is allowed.

Requests enter on a valid/ready channel and verdicts leave on a second valid/ready channel, one response per request. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Its response appears on the next cycle and stays valid and unchanged until `resp_ready` is high at a clock edge. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. The block therefore sustains one request per cycle when the consumer never stalls, and it pushes back for exactly as long as the consumer stalls.

Top module: `pmp_access_checker`

## Requirements
- R1: A read access (`req_acc` = 5'b00001) in a region that enforces permissions is allowed only when that region's R bit is set.
- R2: A write access (5'b00010) needs W. A read-modify-write access (5'b00100) needs both R and W.
- R3: An instruction fetch (5'b01000) needs X.
- R4: A cache-block maintenance access (5'b10000) needs both R and W. X alone, R alone or W alone is not enough.
- R5: An allowed access reports cause 0. A denied fetch reports cause 1, and a denied read reports cause 5. A denied write, read-modify-write or cache access reports cause 7.
- R6: Machine mode is `req_priv` = 2'b11, and every other code is a lower mode. In machine mode, a matched region whose lock bit is clear allows every one-hot access. A locked region enforces R1 to R4.
- R7: When no region matches, `resp_hit` is 0, machine mode is allowed, and lower modes are denied with the class cause of R5.
- R8: When several regions match, the lowest index decides the verdict, and `resp_idx` reports that index with `resp_hit` = 1.
- R9: Match modes are 2'b00 off, 2'b01 top-of-range and 2'b11 power-of-two, and 2'b10 behaves as off. Top-of-range region i matches byte addresses in [4*addr[i-1], 4*addr[i]), with a lower bound of 0 for region 0. A power-of-two region whose address word has k trailing ones covers 2^(k+3) bytes, based at 4*addr with the low k bits of addr cleared.
- R10: A `req_acc` value that is not one-hot is denied with cause 7 in every mode, whether or not a region matches.
- R11: `resp_csub` maps `req_cbo` as follows: clean (0) and flush (1) give 0, invalidate (2) gives 1, and zero (3) gives 2.
- R12: `req_ready` equals (!resp_valid || resp_ready). An accepted request produces `resp_valid` on the next cycle. While `resp_valid` is high and `resp_ready` is low, every response output holds its value.
- R13: During and just after reset, `resp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rwx | input | NUM_REGIONS*3 | Per-region permissions: bit 3i is R, bit 3i+1 is W, bit 3i+2 is X |
| cfg_lock | input | NUM_REGIONS | Per-region lock bit |
| cfg_mode | input | NUM_REGIONS*2 | Per-region match mode (R9) |
| cfg_addr | input | NUM_REGIONS*(PHYS_W-2) | Per-region address word, in units of 4 bytes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | PHYS_W | Physical byte address |
| req_acc | input | 5 | One-hot access class: bit 0 read, bit 1 write, bit 2 read-modify-write, bit 3 fetch, bit 4 cache |
| req_priv | input | 2 | Privilege mode; 2'b11 is machine mode |
| req_cbo | input | 2 | Cache operation: 0 clean, 1 flush, 2 invalidate, 3 zero |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_allow | output | 1 | Access allowed |
| resp_cause | output | 4 | Exception cause on denial, 0 when allowed |
| resp_csub | output | 2 | Cache subtype (R11) |
| resp_hit | output | 1 | A region matched |
| resp_idx | output | IDX_W | Index of the deciding region |

## Verification
The bench aims at cache-maintenance accesses in regions that grant only R, only W, or X without W. A checker that reused the read or write rule for this class would allow one of these accesses, or would report cause 5 in place of 7. It also builds overlapping regions whose permissions disagree: a search in the wrong order shows up as a wrong `resp_idx` and a wrong verdict. Machine mode is tested in locked and unlocked regions and with no match at all, where a wrong polarity on the lock bit or the machine-mode check flips the verdict. Non-one-hot access codes, power-of-two regions at their edge bytes, top-of-range regions with an empty range, and response stalls complete the set. Under a stall, an output register that did not hold its value would show changed fields or a lost response.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;
  localparam int ACC_W     = 5;
  localparam int ACC_RD    = 0;
  localparam int ACC_WR    = 1;
  localparam int ACC_RMW   = 2;
  localparam int ACC_FETCH = 3;
  localparam int ACC_CACHE = 4;

  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_IFETCH = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD   = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE  = 4'd7;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef enum logic [1:0] {
    MM_OFF   = 2'b00,
    MM_TOR   = 2'b01,
    MM_RSVD  = 2'b10,
    MM_NAPOT = 2'b11
  } match_mode_e;

  typedef enum logic [1:0] {
    CBO_CLEAN = 2'd0,
    CBO_FLUSH = 2'd1,
    CBO_INVAL = 2'd2,
    CBO_ZERO  = 2'd3
  } cbo_op_e;

  typedef enum logic [1:0] {
    CSUB_CLEANFLUSH = 2'd0,
    CSUB_INVAL      = 2'd1,
    CSUB_ZERO       = 2'd2
  } csub_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
    logic lock;
  } region_perm_t;
endpackage

// File: rtl/pmpc_region_match.sv
module pmpc_region_match #(
  parameter int PHYS_W = 32,
  localparam int AW = PHYS_W - 2
) (
  input  logic [PHYS_W-1:0] addr,
  input  logic [AW-1:0]     lo_word,
  input  logic [AW-1:0]     cfg_word,
  input  logic [1:0]        mode,
  output logic              hit
);
  import pmpc_pkg::*;

  logic [PHYS_W-1:0] lo_byte, hi_byte, napot_mask;
  logic              tor_hit, napot_hit;

  always_comb begin
    lo_byte    = {lo_word, 2'b00};
    hi_byte    = {cfg_word, 2'b00};
    // trailing ones plus the next zero bit, widened by the two byte bits
    napot_mask = {cfg_word ^ (cfg_word + AW'(1)), 2'b11};
    tor_hit    = (addr >= lo_byte) && (addr < hi_byte);
    napot_hit  = ((addr ^ hi_byte) & ~napot_mask) == '0;
    unique case (match_mode_e'(mode))
      MM_TOR:   hit = tor_hit;
      MM_NAPOT: hit = napot_hit;
      default:  hit = 1'b0;
    endcase
  end

  // R9: an empty top-of-range window can never match
  always_comb begin
    if (match_mode_e'(mode) == MM_TOR && cfg_word <= lo_word)
      a_r9_empty_tor: assert (!hit);
  end
endmodule

// File: rtl/pmpc_prio_sel.sv
module pmpc_prio_sel #(
  parameter int NUM_REGIONS = 4,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [NUM_REGIONS-1:0] hits,
  output logic                   found,
  output logic [IDX_W-1:0]       idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R8: the chosen region matches and no lower one does
  always_comb begin
    if (found)
      a_r8_lowest_wins: assert (hits[idx] &&
        ((hits & ((NUM_REGIONS'(1) << idx) - NUM_REGIONS'(1))) == '0));
  end
endmodule

// File: rtl/pmpc_perm_eval.sv
module pmpc_perm_eval (
  input  logic [pmpc_pkg::ACC_W-1:0]   acc,
  input  logic [1:0]                   priv,
  input  logic                         found,
  input  pmpc_pkg::region_perm_t       perm,
  output logic                         allow,
  output logic [pmpc_pkg::CAUSE_W-1:0] cause
);
  import pmpc_pkg::*;

  logic                is_onehot, is_machine, perm_ok;
  logic [CAUSE_W-1:0]  class_cause;

  always_comb begin
    is_onehot  = (acc != '0) && ((acc & (acc - ACC_W'(1))) == '0);
    is_machine = (priv == PRIV_MACHINE);

    perm_ok = 1'b0;
    if (acc[ACC_RD])    perm_ok = perm.r;
    if (acc[ACC_WR])    perm_ok = perm.w;
    if (acc[ACC_RMW])   perm_ok = perm.r & perm.w;
    if (acc[ACC_FETCH]) perm_ok = perm.x;
    if (acc[ACC_CACHE]) perm_ok = perm.r & perm.w;

    if (is_onehot && acc[ACC_FETCH])   class_cause = CAUSE_IFETCH;
    else if (is_onehot && acc[ACC_RD]) class_cause = CAUSE_LOAD;
    else                               class_cause = CAUSE_STORE;

    if (!is_onehot)                  allow = 1'b0;
    else if (!found)                 allow = is_machine;
    else if (is_machine && !perm.lock) allow = 1'b1;
    else                             allow = perm_ok;

    cause = allow ? CAUSE_NONE : class_cause;
  end

  always_comb begin
    // R4: cache maintenance under enforcement needs both R and W
    if (allow && found && acc == 5'b10000 && (!is_machine || perm.lock))
      a_r4_cache_rw: assert (perm.r && perm.w);
    // R10: malformed class is never allowed
    if (!is_onehot)
      a_r10_malformed: assert (!allow && cause == CAUSE_STORE);
  end
endmodule

// File: rtl/pmpc_cbo_map.sv
module pmpc_cbo_map (
  input  logic [1:0] cbo,
  output logic [1:0] csub
);
  import pmpc_pkg::*;

  always_comb begin
    unique case (cbo_op_e'(cbo))
      CBO_CLEAN, CBO_FLUSH: csub = CSUB_CLEANFLUSH;
      CBO_INVAL:            csub = CSUB_INVAL;
      default:              csub = CSUB_ZERO;
    endcase
  end
endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker #(
  parameter int NUM_REGIONS = 4,
  parameter int PHYS_W = 32,
  localparam int AW = PHYS_W - 2,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGIONS*3-1:0]  cfg_rwx,
  input  logic [NUM_REGIONS-1:0]    cfg_lock,
  input  logic [NUM_REGIONS*2-1:0]  cfg_mode,
  input  logic [NUM_REGIONS*AW-1:0] cfg_addr,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [PHYS_W-1:0]         req_addr,
  input  logic [4:0]                req_acc,
  input  logic [1:0]                req_priv,
  input  logic [1:0]                req_cbo,
  output logic                      resp_valid,
  input  logic                      resp_ready,
  output logic                      resp_allow,
  output logic [3:0]                resp_cause,
  output logic [1:0]                resp_csub,
  output logic                      resp_hit,
  output logic [IDX_W-1:0]          resp_idx
);
  import pmpc_pkg::*;

  logic [NUM_REGIONS-1:0] hits;
  region_perm_t           perms [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [AW-1:0] lo_word;
    if (g == 0) begin : g_base
      assign lo_word = '0;
    end else begin : g_prev
      assign lo_word = cfg_addr[(g-1)*AW +: AW];
    end
    assign perms[g] = '{r: cfg_rwx[3*g], w: cfg_rwx[3*g+1],
                        x: cfg_rwx[3*g+2], lock: cfg_lock[g]};
    pmpc_region_match #(.PHYS_W(PHYS_W)) u_match (
      .addr     (req_addr),
      .lo_word  (lo_word),
      .cfg_word (cfg_addr[g*AW +: AW]),
      .mode     (cfg_mode[2*g +: 2]),
      .hit      (hits[g])
    );
  end

  logic             found;
  logic [IDX_W-1:0] sel_idx;
  region_perm_t     sel_perm;
  logic             n_allow;
  logic [3:0]       n_cause;
  logic [1:0]       n_csub;

  pmpc_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .hits  (hits),
    .found (found),
    .idx   (sel_idx)
  );

  assign sel_perm = perms[sel_idx];

  pmpc_perm_eval u_perm (
    .acc   (req_acc),
    .priv  (req_priv),
    .found (found),
    .perm  (sel_perm),
    .allow (n_allow),
    .cause (n_cause)
  );

  pmpc_cbo_map u_cbo (
    .cbo  (req_cbo),
    .csub (n_csub)
  );

  logic accept;
  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      resp_cause <= '0;
      resp_csub  <= '0;
      resp_hit   <= 1'b0;
      resp_idx   <= '0;
    end else begin
      if (accept) begin
        resp_valid <= 1'b1;
        resp_allow <= n_allow;
        resp_cause <= n_cause;
        resp_csub  <= n_csub;
        resp_hit   <= found;
        resp_idx   <= sel_idx;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

  a_r12_accept_to_resp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_allow) &&
      $stable(resp_cause) && $stable(resp_csub) && $stable(resp_hit) && $stable(resp_idx));
  a_r5_allow_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_allow |-> resp_cause == 4'd0);
  a_r5_deny_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_allow |-> resp_cause != 4'd0);
endmodule

// File: tb/pmp_access_checker_tb_top.sv
`timescale 1ns/1ps
module pmp_access_checker_tb_top;
  localparam int N  = 4;
  localparam int PW = 32;
  localparam int AW = PW - 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          b_r [N], b_w [N], b_x [N], b_l [N];
  logic [1:0]    b_mode [N];
  logic [AW-1:0] b_addr [N];

  logic [N*3-1:0]  cfg_rwx;
  logic [N-1:0]    cfg_lock;
  logic [N*2-1:0]  cfg_mode;
  logic [N*AW-1:0] cfg_addr;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_rwx[3*i] = b_r[i]; cfg_rwx[3*i+1] = b_w[i]; cfg_rwx[3*i+2] = b_x[i];
      cfg_lock[i] = b_l[i];
      cfg_mode[2*i +: 2] = b_mode[i];
      cfg_addr[i*AW +: AW] = b_addr[i];
    end
  end

  logic          req_valid = 0, resp_ready = 0;
  logic [PW-1:0] req_addr = '0;
  logic [4:0]    req_acc = '0;
  logic [1:0]    req_priv = '0, req_cbo = '0;
  logic          req_ready, resp_valid, resp_allow, resp_hit;
  logic [3:0]    resp_cause;
  logic [1:0]    resp_csub;
  logic [IW-1:0] resp_idx;

  pmp_access_checker #(.NUM_REGIONS(N), .PHYS_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rwx(cfg_rwx), .cfg_lock(cfg_lock),
    .cfg_mode(cfg_mode), .cfg_addr(cfg_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_acc(req_acc),
    .req_priv(req_priv), .req_cbo(req_cbo), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_allow(resp_allow), .resp_cause(resp_cause),
    .resp_csub(resp_csub), .resp_hit(resp_hit), .resp_idx(resp_idx)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, string what, longint got, longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit region_hit(int i, longint unsigned a);
    longint unsigned lo, hi, base, size, w;
    int k;
    w = longint'(b_addr[i]);
    if (b_mode[i] == 2'b01) begin
      lo = (i == 0) ? 0 : longint'(b_addr[i-1]) * 4;
      hi = w * 4;
      return (a >= lo) && (a < hi);
    end else if (b_mode[i] == 2'b11) begin
      k = 0;
      while (k < AW && w[k]) k++;
      size = 64'd1 << (k + 3);
      base = (w * 4) & ~(size - 1);
      return (a >= base) && (a < base + size);
    end
    return 0;
  endfunction

  function automatic void model(longint unsigned a, logic [4:0] acc, logic [1:0] priv,
                                output bit allow, output int cause,
                                output bit hit, output int idx);
    bit mach, ok, oh;
    int cls;
    hit = 0; idx = 0;
    for (int i = 0; i < N; i++)
      if (!hit && region_hit(i, a)) begin hit = 1; idx = i; end
    mach = (priv == 2'b11);
    oh = (acc == 5'b00001) || (acc == 5'b00010) || (acc == 5'b00100) ||
         (acc == 5'b01000) || (acc == 5'b10000);
    case (acc)
      5'b00001: begin ok = b_r[idx];            cls = 5; end
      5'b00010: begin ok = b_w[idx];            cls = 7; end
      5'b00100: begin ok = b_r[idx] && b_w[idx]; cls = 7; end
      5'b01000: begin ok = b_x[idx];            cls = 1; end
      5'b10000: begin ok = b_r[idx] && b_w[idx]; cls = 7; end
      default:  begin ok = 0;                   cls = 7; end
    endcase
    if (!oh)                    allow = 0;
    else if (!hit)              allow = mach;
    else if (mach && !b_l[idx]) allow = 1;
    else                        allow = ok;
    cause = allow ? 0 : cls;
  endfunction

  function automatic int csub_of(logic [1:0] c);
    return (c == 2'd2) ? 1 : (c == 2'd3) ? 2 : 0;
  endfunction

  function automatic string tag_of(logic [4:0] acc);
    case (acc)
      5'b00001: return "R1";
      5'b00010: return "R2";
      5'b00100: return "R2";
      5'b01000: return "R3";
      5'b10000: return "R4";
      default:  return "R10";
    endcase
  endfunction

  task automatic txn(longint unsigned a, logic [4:0] acc, logic [1:0] priv,
                     logic [1:0] cbo, int stall, string tag);
    bit e_allow, e_hit; int e_cause, e_idx;
    model(a, acc, priv, e_allow, e_cause, e_hit, e_idx);
    @(negedge clk);
    req_addr = a[PW-1:0]; req_acc = acc; req_priv = priv; req_cbo = cbo;
    req_valid = 1; resp_ready = (stall == 0);
    chk("R12", "req_ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R12", "resp_valid", resp_valid, 1);
    chk(tag, "allow", resp_allow, e_allow);
    chk("R5", "cause", resp_cause, e_cause);
    chk("R11", "csub", resp_csub, csub_of(cbo));
    chk("R8", "hit", resp_hit, e_hit);
    if (e_hit) chk("R8", "idx", resp_idx, e_idx);
    for (int s = 0; s < stall; s++) begin
      chk("R12", "req_ready stalled", req_ready, 0);
      @(negedge clk);
      chk("R12", "held valid", resp_valid, 1);
      chk("R12", "held allow", resp_allow, e_allow);
      chk("R12", "held cause", resp_cause, e_cause);
    end
    resp_ready = 1;
    @(negedge clk);
    chk("R12", "drained", resp_valid, 0);
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < N; i++) begin
      b_r[i] = 0; b_w[i] = 0; b_x[i] = 0; b_l[i] = 0; b_mode[i] = 2'b00; b_addr[i] = '0;
    end
  endtask

  task automatic rand_cfg();
    int k; logic [AW-1:0] v;
    for (int i = 0; i < N; i++) begin
      b_r[i] = 1'($urandom); b_w[i] = 1'($urandom); b_x[i] = 1'($urandom);
      b_l[i] = 1'($urandom); b_mode[i] = 2'($urandom);
      if (b_mode[i] == 2'b11) begin
        k = $urandom_range(0, 8);
        v = AW'($urandom_range(0, 4095));
        v = (v & ~AW'((1 << (k + 1)) - 1)) | AW'((1 << k) - 1);
        b_addr[i] = v;
      end else b_addr[i] = AW'($urandom_range(0, 4095));
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] acc; logic [1:0] priv;
    void'($urandom(32'd1234));
    clear_cfg();
    repeat (3) @(negedge clk);
    chk("R13", "resp_valid in reset", resp_valid, 0);
    chk("R13", "req_ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R13", "resp_valid after reset", resp_valid, 0);

    // R7: no regions configured
    txn(64'h100, 5'b00001, 2'b00, 0, 0, "R7");
    txn(64'h100, 5'b01000, 2'b01, 0, 0, "R7");
    txn(64'h100, 5'b10000, 2'b11, 0, 0, "R7");
    // R10: malformed class, even in machine mode with no match
    txn(64'h100, 5'b00000, 2'b11, 0, 0, "R10");
    txn(64'h100, 5'b00011, 2'b00, 0, 0, "R10");

    // region 0: NAPOT 32 bytes at 0x100 (word 0x40 | 0b11), R only
    b_mode[0] = 2'b11; b_addr[0] = AW'(30'h43); b_r[0] = 1;
    txn(64'h100, 5'b00001, 2'b00, 0, 0, "R1");
    txn(64'h11F, 5'b00001, 2'b00, 0, 0, "R9");
    txn(64'h120, 5'b00001, 2'b00, 0, 0, "R9");
    txn(64'h104, 5'b00010, 2'b00, 0, 0, "R2");
    txn(64'h104, 5'b10000, 2'b01, 0, 0, "R4");
    // W only and X only: cache still denied
    b_r[0] = 0; b_w[0] = 1;
    txn(64'h104, 5'b10000, 2'b00, 2, 0, "R4");
    txn(64'h104, 5'b00100, 2'b00, 0, 0, "R2");
    b_w[0] = 0; b_x[0] = 1;
    txn(64'h104, 5'b10000, 2'b00, 3, 0, "R4");
    txn(64'h104, 5'b01000, 2'b00, 0, 0, "R3");
    b_r[0] = 1; b_w[0] = 1; b_x[0] = 0;
    txn(64'h104, 5'b10000, 2'b00, 1, 0, "R4");
    txn(64'h104, 5'b01000, 2'b00, 0, 0, "R3");
    // R6: machine mode unlocked vs locked
    b_r[0] = 0; b_w[0] = 0;
    txn(64'h104, 5'b00010, 2'b11, 0, 0, "R6");
    b_l[0] = 1;
    txn(64'h104, 5'b00010, 2'b11, 0, 0, "R6");
    txn(64'h104, 5'b00010, 2'b10, 0, 0, "R6");
    // R8: overlapping TOR region 1 [0x10C,0x200) grants all; region 0 decides
    b_mode[1] = 2'b01; b_addr[1] = AW'(30'h80); b_r[1] = 1; b_w[1] = 1; b_x[1] = 1;
    txn(64'h110, 5'b00001, 2'b00, 0, 0, "R8");
    txn(64'h180, 5'b00001, 2'b00, 0, 0, "R8");
    txn(64'h1FF, 5'b00001, 2'b00, 0, 0, "R9");
    txn(64'h200, 5'b00001, 2'b00, 0, 0, "R9");
    // empty TOR: region 2 below region 1's address
    b_mode[2] = 2'b01; b_addr[2] = AW'(30'h10); b_r[2] = 1;
    txn(64'h30, 5'b00001, 2'b00, 0, 0, "R9");
    // stalls
    txn(64'h180, 5'b10000, 2'b00, 2, 3, "R12");

    for (int t = 0; t < 3000; t++) begin
      if (t % 150 == 0) rand_cfg();
      if ($urandom_range(0, 99) < 85) acc = 5'(1 << $urandom_range(0, 4));
      else acc = 5'($urandom);
      priv = 2'($urandom);
      txn(longint'($urandom_range(0, 32'h4100)), acc, priv, 2'($urandom),
          ($urandom_range(0, 9) == 0) ? $urandom_range(1, 3) : 0, tag_of(acc));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule